// File: doc/BRIEF.md
# Byte-Lane Simple Dual-Port RAM

A single-clock memory with one write port and one read port. The data word is split into byte lanes of nine bits each. Each lane has its own enable, so one write can update any subset of the lanes. The ninth bit of every lane is plain storage. It may carry parity or extra data, but the memory neither generates nor checks it.

Read data is registered. A read enable captures the word at the read address on a clock edge, and the output holds while the read enable stays low.

A compile-time parameter decides what a read returns when it targets the word being written in the same cycle:

- the contents from before the write,
- the merged word after the write, or
- an undefined value, for callers that never rely on it.

Top module: `sdp_ram_be`

## Requirements
- R1: While rst_ni is low, rd_data_o is all zeros.
- R2: When rd_en_i is high at a rising edge, rd_data_o shows the word stored at rd_addr_i from that edge until the next read.
- R3: When rd_en_i is low at a rising edge, rd_data_o keeps its previous value, even if writes happen.
- R4: When wr_en_i is low, no word changes, whatever wr_be_i and wr_data_i carry.
- R5: Lane i is data bits [9i+8:9i] and is written only when wr_be_i[i] is high together with wr_en_i. Lanes whose enable is low keep their earlier contents.
- R6: Bit 9i+8 of each lane is stored and returned unchanged like any other data bit, and no parity is computed on it.
- R7: With RDW = RDW_OLD (0), a read at the address being written in the same cycle returns the word from before that write.
- R8: With RDW = RDW_NEW (1), such a colliding read returns the merged word. Enabled lanes hold the new data and disabled lanes hold the old contents.
- R9: With RDW = RDW_DONTCARE (2), a colliding read returns an undefined value, and reads that do not collide behave as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the read register |
| wr_en_i | input | 1 | Write enable |
| wr_be_i | input | LANES | Per-lane write enable |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 9*LANES | Write data |
| rd_en_i | input | 1 | Read enable |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 9*LANES | Registered read data |

## Verification
The assertions assume the inputs are at known levels from reset onward. They also assume read enable is low during reset, and the re-read stability property relies on that.

They make no claim about a colliding read in don't-care mode. The re-read property excludes any cycle that follows a write, so an undefined word never reaches its comparison.

The bench follows the same rules. It drives every input from the first edge, holds read enable low while reset is active, and writes every address before reading any of them. A colliding read in don't-care mode is left unchecked until the next read that does not collide.

// File: rtl/sdp_ram_pkg.sv
package sdp_ram_pkg;
  localparam int unsigned LANE_W = 9;

  typedef enum logic [1:0] {
    RDW_OLD      = 2'd0,
    RDW_NEW      = 2'd1,
    RDW_DONTCARE = 2'd2
  } rdw_mode_e;
endpackage

// File: rtl/sdp_ram_store.sv
module sdp_ram_store
  import sdp_ram_pkg::*;
#(
  parameter int unsigned LANES  = 2,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                    clk_i,
  input  logic                    wr_en_i,
  input  logic [LANES-1:0]        wr_be_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [LANES*LANE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [LANES*LANE_W-1:0] rd_word_o
);
  localparam int unsigned DW    = LANES * LANE_W;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_be_i[l]) mem_q[wr_addr_i][l*LANE_W +: LANE_W] <= wr_data_i[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_word_o = mem_q[rd_addr_i];
endmodule

// File: rtl/sdp_ram_rdw.sv
module sdp_ram_rdw
  import sdp_ram_pkg::*;
#(
  parameter int unsigned LANES = 2,
  parameter rdw_mode_e   RDW   = RDW_OLD
) (
  input  logic [LANES*LANE_W-1:0] stored_i,
  input  logic                    wr_en_i,
  input  logic [LANES-1:0]        wr_be_i,
  input  logic [LANES*LANE_W-1:0] wr_data_i,
  input  logic                    addr_hit_i,
  output logic [LANES*LANE_W-1:0] next_o
);
  localparam int unsigned DW = LANES * LANE_W;

  logic [DW-1:0] merged;
  logic          collide;

  assign collide = wr_en_i & addr_hit_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] = wr_be_i[l] ? wr_data_i[l*LANE_W +: LANE_W]
                                                   : stored_i[l*LANE_W +: LANE_W];
  end

  if (RDW == RDW_NEW) begin : g_new
    assign next_o = collide ? merged : stored_i;
  end else if (RDW == RDW_DONTCARE) begin : g_dc
    logic unused_merge;
    assign unused_merge = ^merged;
    assign next_o = collide ? {DW{1'bx}} : stored_i;
  end else begin : g_old
    logic unused_merge;
    assign unused_merge = ^{merged, collide};
    assign next_o = stored_i;
  end
endmodule

// File: rtl/sdp_ram_rdreg.sv
module sdp_ram_rdreg #(
  parameter int unsigned DW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/sdp_ram_be.sv
module sdp_ram_be
  import sdp_ram_pkg::*;
#(
  parameter int unsigned LANES  = 2,
  parameter int unsigned ADDR_W = 5,
  parameter rdw_mode_e   RDW    = RDW_OLD
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [LANES-1:0]        wr_be_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [LANES*LANE_W-1:0] wr_data_i,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [LANES*LANE_W-1:0] rd_data_o
);
  localparam int unsigned DW = LANES * LANE_W;

  logic [DW-1:0] stored;
  logic [DW-1:0] next_rd;

  sdp_ram_store #(.LANES(LANES), .ADDR_W(ADDR_W)) store_i (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_be_i   (wr_be_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_word_o (stored)
  );

  sdp_ram_rdw #(.LANES(LANES), .RDW(RDW)) rdw_i (
    .stored_i   (stored),
    .wr_en_i    (wr_en_i),
    .wr_be_i    (wr_be_i),
    .wr_data_i  (wr_data_i),
    .addr_hit_i (wr_addr_i == rd_addr_i),
    .next_o     (next_rd)
  );

  sdp_ram_rdreg #(.DW(DW)) rdreg_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rd_en_i),
    .d_i    (next_rd),
    .q_o    (rd_data_o)
  );
endmodule

// File: rtl/sdp_ram_be_chk.sv
module sdp_ram_be_chk
  import sdp_ram_pkg::*;
#(
  parameter int unsigned LANES  = 2,
  parameter int unsigned ADDR_W = 5,
  parameter rdw_mode_e   RDW    = RDW_OLD
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    wr_en_i,
  input logic [LANES-1:0]        wr_be_i,
  input logic [ADDR_W-1:0]       wr_addr_i,
  input logic [LANES*LANE_W-1:0] wr_data_i,
  input logic                    rd_en_i,
  input logic [ADDR_W-1:0]       rd_addr_i,
  input logic [LANES*LANE_W-1:0] rd_data_o
);
  p_reset_zero_r1: assert property (@(posedge clk_i) !rst_ni |-> rd_data_o == '0);

  p_hold_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  // R2: re-reading an untouched address gives the same word
  p_reread_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && $past(rd_en_i) && rd_addr_i == $past(rd_addr_i) && !$past(wr_en_i)
     && !(wr_en_i && wr_addr_i == rd_addr_i))
    |=> rd_data_o == $past(rd_data_o));

  if (RDW == RDW_NEW) begin : g_new
    p_new_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && wr_en_i && wr_addr_i == rd_addr_i && &wr_be_i)
      |=> rd_data_o == $past(wr_data_i));
  end else begin : g_other
    logic unused_chk;
    assign unused_chk = ^{wr_be_i, wr_data_i};
  end
endmodule

bind sdp_ram_be sdp_ram_be_chk #(.LANES(LANES), .ADDR_W(ADDR_W), .RDW(RDW)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_be_i   (wr_be_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .rd_en_i   (rd_en_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o)
);

// File: tb/sdp_ram_be_tb_top.sv
module sdp_ram_be_tb_top;
  import sdp_ram_pkg::*;

  localparam int unsigned LANES  = 2;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DW     = LANES * 9;
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam time         CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              we = 1'b0;
  logic [LANES-1:0]  be = '0;
  logic [ADDR_W-1:0] wa = '0;
  logic [DW-1:0]     wd = '0;
  logic              re = 1'b0;
  logic [ADDR_W-1:0] ra = '0;
  logic [DW-1:0]     rd_q [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar m = 0; m < 3; m++) begin : g_mode
    sdp_ram_be #(.LANES(LANES), .ADDR_W(ADDR_W), .RDW(rdw_mode_e'(m))) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_be_i(be), .wr_addr_i(wa),
      .wr_data_i(wd), .rd_en_i(re), .rd_addr_i(ra), .rd_data_o(rd_q[m])
    );
  end

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] shadow [DEPTH];
  logic [DW-1:0] exp_q [3];
  bit            vld_q [3];

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [LANES-1:0] en, logic [DW-1:0] nw);
    logic [DW-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*9 +: 9] = en[l] ? nw[l*9 +: 9] : old[l*9 +: 9];
    return r;
  endfunction

  task automatic check_all(string req);
    for (int m = 0; m < 3; m++) begin
      if (vld_q[m]) begin
        checks++;
        if (rd_q[m] !== exp_q[m]) begin
          errors++;
          $display("FAIL %s mode %0d: rd_data=%h expected=%h", req, m, rd_q[m], exp_q[m]);
        end
      end
    end
  endtask

  // inputs change at negedge; outputs checked at the following negedge
  task automatic step(string req, logic w, logic [LANES-1:0] b, logic [ADDR_W-1:0] a,
                      logic [DW-1:0] d, logic r, logic [ADDR_W-1:0] q);
    logic coll;
    we = w; be = b; wa = a; wd = d; re = r; ra = q;
    coll = w && (a == q);
    if (r) begin
      exp_q[0] = shadow[q];
      exp_q[1] = coll ? merge(shadow[q], b, d) : shadow[q];
      exp_q[2] = shadow[q];
      vld_q[2] = !coll;
    end
    if (w) shadow[a] = merge(shadow[a], b, d);
    @(posedge clk);
    @(negedge clk);
    check_all(req);
  endtask

  function automatic logic [DW-1:0] pat(int a, int k);
    return DW'((a * 16'h2c9 + k * 16'h1b3 + 18'h20100) ^ (a << 9));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int m = 0; m < 3; m++) begin exp_q[m] = '0; vld_q[m] = 1'b1; end
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // fill every word with reads idle: output must stay zero
    for (int a = 0; a < DEPTH; a++) step("R3", 1'b1, '1, ADDR_W'(a), pat(a, 0), 1'b0, '0);

    // back-to-back reads of the whole array
    for (int a = 0; a < DEPTH; a++) step("R2", 1'b0, '0, '0, '0, 1'b1, ADDR_W'(a));

    // every lane-enable pattern, ninth bits set in data, read back later
    for (int a = 0; a < DEPTH; a++) begin
      for (int b = 0; b < (1 << LANES); b++) begin
        step("R5", 1'b1, LANES'(b), ADDR_W'(a), pat(a, b + 1) | 18'h20100, 1'b0, '0);
        step("R5 R6", 1'b0, '0, '0, '0, 1'b1, ADDR_W'(a));
      end
    end

    // write enable low: all lanes enabled but nothing may change
    for (int a = 0; a < DEPTH; a++) begin
      step("R4", 1'b0, '1, ADDR_W'(a), ~shadow[a], 1'b0, '0);
      step("R4", 1'b0, '0, '0, '0, 1'b1, ADDR_W'(a));
    end

    // forced collisions per enable pattern, then a clean re-read
    for (int a = 0; a < DEPTH; a++) begin
      for (int b = 0; b < (1 << LANES); b++) begin
        step("R7 R8 R9", 1'b1, LANES'(b), ADDR_W'(a), pat(a, b + 7), 1'b1, ADDR_W'(a));
        step("R9", 1'b0, '0, '0, '0, 1'b1, ADDR_W'(a));
      end
    end

    // idle reads while the last-read word is overwritten
    step("R2", 1'b0, '0, '0, '0, 1'b1, 5'd3);
    step("R3", 1'b1, '1, 5'd3, 18'h3ffff, 1'b0, 5'd3);
    step("R3", 1'b1, '1, 5'd3, 18'h00000, 1'b0, 5'd3);

    // random mix with frequent collisions
    for (int i = 0; i < 4000; i++) begin
      logic [ADDR_W-1:0] a, q;
      a = ADDR_W'($urandom);
      q = ($urandom % 4 == 0) ? a : ADDR_W'($urandom);
      step("R5 R7 R8", 1'($urandom), LANES'($urandom), a, DW'($urandom), 1'($urandom), q);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule